// File: doc/BRIEF.md
# Key-Gated Serial Register Access Controller

This controller sits beside a byte-wide memory on its bus. It sees one strobe per bus cycle (read or write) and bit 0 of the data bus. Normally every cycle reaches the memory. A hidden 64-bit register image, holding eight calendar bytes, can be reached only by first issuing a read, which arms a bit pointer at key position 0. Then 64 back-to-back writes must carry the right key bit on data bit 0. The key writes themselves still land in memory.

Once the full key has matched, the next 64 strobed cycles bypass memory and move one register bit per cycle on data bit 0. Reads shift out a snapshot of the image taken when the key completed. Writes shift bits into a shadow copy, which is handed to the register image as a single load only if all 64 cycles were writes. An external reset pin can cut a transfer short when the reset-enable control allows it.

Top module: `keyed_serial_port`

## Requirements
- R1: After reset `mem_block`, `load_stb` and `dq0_out` are 0 and the pointer is not armed, so writes of the full key with no read before them do not unlock.
- R2: A cycle with `rd_cyc` high (also when `wr_cyc` is high in the same cycle) outside a transfer sets the pointer to key bit 0 and arms it, which abandons any partial match.
- R3: The key bit for position i is bit i%8 of byte i/8 of the list C5, 3A, A3, 5C, C5, 3A, A3, 5C. An armed write whose `dq0_in` equals the key bit at the pointer advances the pointer. The 64th matching write raises `mem_block` from the next cycle. Cycles with no strobe change nothing.
- R4: A write that does not match disarms the pointer, so the remaining writes of that attempt cannot unlock until another read.
- R5: `mem_block` stays 0 for every cycle before the key completes, including during the key writes.
- R6: During a transfer `dq0_out` equals bit k of the image captured at the edge that accepted the last key bit, where k is the count of strobed transfer cycles so far. Image bit 8r+b is register r bit b. Later changes of `reg_image` do not affect it.
- R7: If all 64 transfer cycles are writes, `load_data` bit k equals `dq0_in` of transfer write k. `load_stb` is high for exactly the one cycle after the clock edge that follows the edge of the 64th write.
- R8: After the 64th strobed transfer cycle `mem_block` returns to 0. A transfer that contains any read produces no `load_stb` and leaves `load_data` unchanged.
- R9: With `rst_ignore`=0, a low `reset_pin_n` during a transfer ends it: `mem_block` is 0 from the next cycle, with no `load_stb` and `load_data` unchanged.
- R10: With `rst_ignore`=1, `reset_pin_n` has no effect on a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_cyc | input | 1 | One-cycle read strobe for a bus cycle |
| wr_cyc | input | 1 | One-cycle write strobe for a bus cycle |
| dq0_in | input | 1 | Data bit 0 of the bus on write cycles |
| reset_pin_n | input | 1 | External active-low transfer abort pin |
| rst_ignore | input | 1 | 1 = abort pin ignored |
| reg_image | input | 64 | Current register image |
| mem_block | output | 1 | High while cycles go to the register image instead of memory |
| dq0_out | output | 1 | Serial read data for the current transfer cycle |
| load_data | output | 64 | Assembled image for a load |
| load_stb | output | 1 | One-cycle load pulse |

## Verification
The bench flips a single key bit mid-stream and then sends the correct tail. A design that resumed matching after the error would unlock. It reads partway through a key and also issues a cycle carrying both strobes. A design that kept the old pointer, or took the double strobe as a write, would unlock on the leftover bits. It mixes reads into a write transfer and pulls the abort pin partway through. A design that loaded partial shadow data would pulse `load_stb` or corrupt `load_data`. It also changes `reg_image` after unlocking, which catches a design that streams live data instead of the snapshot.

// File: rtl/keyed_serial_port.sv
module keyed_serial_port #(
  parameter int N = 64,
  parameter logic [N-1:0] KEY = 64'h5CA3_3AC5_5CA3_3AC5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rd_cyc,
  input  logic         wr_cyc,
  input  logic         dq0_in,
  input  logic         reset_pin_n,
  input  logic         rst_ignore,
  input  logic [N-1:0] reg_image,
  output logic         mem_block,
  output logic         dq0_out,
  output logic [N-1:0] load_data,
  output logic         load_stb
);
  localparam int PW = $clog2(N);
  localparam logic [PW-1:0] LAST = PW'(N-1);

  logic          xfer, armed, wr_all, commit;
  logic [PW-1:0] ptr, cnt;
  logic [N-1:0]  snap, shadow;

  wire is_rd = rd_cyc;
  wire is_wr = wr_cyc & ~rd_cyc;
  wire abort = xfer & ~rst_ignore & ~reset_pin_n;

  assign mem_block = xfer;
  assign dq0_out   = xfer & snap[cnt];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xfer      <= 1'b0;
      armed     <= 1'b0;
      wr_all    <= 1'b0;
      commit    <= 1'b0;
      ptr       <= '0;
      cnt       <= '0;
      snap      <= '0;
      shadow    <= '0;
      load_data <= '0;
      load_stb  <= 1'b0;
    end else begin
      load_stb <= commit;
      commit   <= 1'b0;
      if (commit) load_data <= shadow;
      if (abort) begin
        xfer <= 1'b0;
      end else if (xfer) begin
        if (is_rd || is_wr) begin
          cnt <= cnt + 1'b1;
          if (is_wr) shadow[cnt] <= dq0_in;
          else       wr_all <= 1'b0;
          if (cnt == LAST) begin
            xfer   <= 1'b0;
            commit <= is_wr & wr_all;
          end
        end
      end else if (is_rd) begin
        ptr   <= '0;
        armed <= 1'b1;
      end else if (is_wr && armed) begin
        if (dq0_in != KEY[ptr]) begin
          armed <= 1'b0;
        end else if (ptr == LAST) begin
          xfer   <= 1'b1;
          armed  <= 1'b0;
          cnt    <= '0;
          wr_all <= 1'b1;
          snap   <= reg_image;
        end else begin
          ptr <= ptr + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/keyed_serial_port_chk.sv
module keyed_serial_port_chk #(parameter int N = 64) (
  input logic         clk,
  input logic         rst_n,
  input logic         rd_cyc,
  input logic         wr_cyc,
  input logic         dq0_in,
  input logic         reset_pin_n,
  input logic         rst_ignore,
  input logic [N-1:0] reg_image,
  input logic         mem_block,
  input logic         dq0_out,
  input logic [N-1:0] load_data,
  input logic         load_stb
);
  // R3
  unlock_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_block) |-> $past(wr_cyc && !rd_cyc));
  // R2
  read_no_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_block && rd_cyc) |=> !mem_block);
  // R9
  pin_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_block && !rst_ignore && !reset_pin_n) |=> !mem_block);
  // R7
  load_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |=> !load_stb);
  // R7
  load_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |-> !mem_block);
  // R8
  load_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_stb |-> $stable(load_data));
  // R6
  dq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_block |-> !dq0_out);
endmodule

bind keyed_serial_port keyed_serial_port_chk #(.N(N)) u_chk (.*);

// File: tb/test_keyed_serial_port.sv
module test_keyed_serial_port;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rd_cyc = 0, wr_cyc = 0, dq0_in = 0, reset_pin_n = 1, rst_ignore = 0;
  logic [63:0] reg_image = '0;
  logic mem_block, dq0_out, load_stb;
  logic [63:0] load_data;

  int checks = 0, fails = 0, loads = 0;

  keyed_serial_port i_keyed_serial_port (.*);

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) if (rst_n && load_stb) loads++;

  function automatic logic key_bit(int i);
    logic [7:0] kb;
    case ((i / 8) % 4)
      0: kb = 8'hC5;
      1: kb = 8'h3A;
      2: kb = 8'hA3;
      default: kb = 8'h5C;
    endcase
    return kb[i % 8];
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(logic r, logic w, logic d);
    rd_cyc = r; wr_cyc = w; dq0_in = d;
    @(negedge clk);
    rd_cyc = 0; wr_cyc = 0;
  endtask

  task automatic send_key(int from, int upto, int flip, output int early);
    early = 0;
    for (int i = from; i < upto; i++) begin
      if (mem_block) early++;
      cyc(0, 1, key_bit(i) ^ (i == flip));
    end
  endtask

  task automatic unlock();
    int e;
    cyc(1, 0, 0);
    send_key(0, 64, -1, e);
    check("R5 no block during key", 64'(e), 64'd0);
    check("R3 unlocked", 64'(mem_block), 64'd1);
  endtask

  task automatic t_reset();
    int e;
    check("R1 mem_block", 64'(mem_block), 0);
    check("R1 load_stb", 64'(load_stb), 0);
    check("R1 dq0_out", 64'(dq0_out), 0);
    send_key(0, 64, -1, e);
    check("R1 unarmed key", 64'(mem_block), 0);
  endtask

  task automatic t_read_xfer();
    logic [63:0] img = 64'h0123_4567_89AB_CDEF;
    int bad = 0;
    reg_image = img;
    unlock();
    reg_image = ~img;
    for (int k = 0; k < 64; k++) begin
      if (dq0_out !== img[k]) bad++;
      cyc(1, 0, 0);
    end
    check("R6 snapshot bits", 64'(bad), 0);
    check("R8 end of read xfer", 64'(mem_block), 0);
  endtask

  task automatic t_write_xfer(logic [63:0] pat, logic pin, logic ign, string req);
    int l0;
    rst_ignore = ign;
    unlock();
    reset_pin_n = pin;
    for (int k = 0; k < 64; k++) cyc(0, 1, pat[k]);
    reset_pin_n = 1;
    check({req, " xfer done"}, 64'(mem_block), 0);
    check({req, " no early load"}, 64'(load_stb), 0);
    l0 = loads;
    cyc(0, 0, 0);
    check({req, " load pulse"}, 64'(load_stb), 1);
    check({req, " load data"}, load_data, pat);
    cyc(0, 0, 0);
    check({req, " pulse one cycle"}, 64'(loads - l0), 1);
    rst_ignore = 0;
  endtask

  task automatic t_mixed(logic [63:0] prev);
    int l0 = loads;
    unlock();
    for (int k = 0; k < 32; k++) cyc(0, 1, 1'b0);
    for (int k = 0; k < 32; k++) cyc(1, 0, 0);
    cyc(0, 0, 0); cyc(0, 0, 0);
    check("R8 mixed ends", 64'(mem_block), 0);
    check("R8 mixed no load", 64'(loads - l0), 0);
    check("R8 mixed data kept", load_data, prev);
  endtask

  task automatic t_mismatch();
    int e;
    cyc(1, 0, 0);
    send_key(0, 64, 5, e);
    check("R4 mismatch locks", 64'(mem_block), 0);
    send_key(0, 64, -1, e);
    check("R4 no rearm by write", 64'(mem_block), 0);
    unlock();
    for (int k = 0; k < 64; k++) cyc(1, 0, 0);
  endtask

  task automatic t_read_abort();
    int e;
    cyc(1, 0, 0);
    send_key(0, 30, -1, e);
    cyc(1, 0, 0);
    send_key(30, 64, -1, e);
    check("R2 read resets pointer", 64'(mem_block), 0);
    cyc(1, 0, 0);
    send_key(0, 20, -1, e);
    cyc(1, 1, key_bit(20));
    send_key(21, 64, -1, e);
    check("R2 double strobe is read", 64'(mem_block), 0);
    cyc(1, 0, 0);
    for (int i = 0; i < 64; i++) begin
      cyc(0, 0, 0);
      cyc(0, 1, key_bit(i));
    end
    check("R3 idle cycles ignored", 64'(mem_block), 1);
    for (int k = 0; k < 64; k++) cyc(1, 0, 0);
  endtask

  task automatic t_pin_abort(logic [63:0] prev);
    int l0 = loads;
    rst_ignore = 0;
    unlock();
    for (int k = 0; k < 10; k++) cyc(0, 1, 1'b1);
    reset_pin_n = 0;
    cyc(0, 0, 0);
    reset_pin_n = 1;
    check("R9 abort ends xfer", 64'(mem_block), 0);
    cyc(0, 0, 0); cyc(0, 0, 0);
    check("R9 abort no load", 64'(loads - l0), 0);
    check("R9 abort data kept", load_data, prev);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_read_xfer();
    t_write_xfer(64'hDEAD_BEEF_0F1E_2D3C, 1'b1, 1'b0, "R7");
    t_mixed(64'hDEAD_BEEF_0F1E_2D3C);
    t_mismatch();
    t_read_abort();
    t_pin_abort(64'hDEAD_BEEF_0F1E_2D3C);
    t_write_xfer(64'h5555_AAAA_F00F_1234, 1'b0, 1'b1, "R10");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule